// File: doc/BRIEF.md
# SMBus Byte-Register Target

This block is a two-wire serial target that lets a host read and write one byte at a time in a byte-indexed register space. A fast system clock oversamples the clock and data lines, and the block pulls the data line low through an output-enable, as an open-drain pad needs. A write is a START, an address byte with the direction bit low, an index byte, a data byte and a STOP. A read sends the index the same way, then a repeated START, the address with the direction bit high, and one byte from the target, which the host NACKs before its STOP.

The 7-bit target address has a fixed upper nibble (binary 0011 by default). The three low bits come from strap pins. They are captured while the system reset or the external active-low reset is asserted, and held afterwards, so the pins are free to act as ordinary I/O. The register file sits outside the block. The block presents the index, write data with a one-cycle write strobe, and a one-cycle read strobe, so that registers which clear on read can react. Two chip-identity indices are answered inside the block, and writes to them are dropped.

Top module: `smbus_reg_target`

## Requirements
- R1: While reset is asserted, and after it is released, `sda_oe`, `reg_we` and `reg_re` are low.
- R2: An address byte whose upper seven bits equal {0011, strap[2:0]} is acknowledged. The strap value used is the one captured during reset. Bit 0 of the address byte is the direction bit: 0 means write, 1 means read.
- R3: An address byte with any other upper seven bits is not acknowledged. The target then ignores the bus until the next START and produces no strobe.
- R4: In a write, all three bytes are acknowledged. After the eighth bit of the data byte, `reg_we` pulses for exactly one cycle, with `reg_idx` holding the index byte and `reg_wdata` holding the data byte.
- R5: In a read, the target returns the byte at the previously sent index, MSB first. `reg_re` pulses exactly once per read, never in the same cycle as `reg_we`.
- R6: Index 0x20 reads as 0x60 and index 0x21 reads as 0x13, whatever `reg_rdata` holds. A write to either index is acknowledged but produces no `reg_we`.
- R7: A change on the strap pins after reset has no effect on the address. A pulse on `ext_rst_n` captures the new strap value.
- R8: A START that arrives part way through the data byte of a write aborts it without a write strobe. The target then decodes the new address byte normally.
- R9: `sda_oe` only becomes asserted while the synchronized clock line is low, and it is released after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| ext_rst_n | input | 1 | Active-low external reset pin, reloads the address strap |
| addr_strap | input | 3 | Low address bits, sampled during reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_idx | output | 8 | Register index from the host |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data for `reg_idx` |

## Verification
Two events can fall in the same cycle here: a repeated START on the bus and the commit of a data byte that is still arriving. Whichever reaches the state machine first decides whether a write strobe appears. The bench provokes this by stopping the data byte after four bits and raising a START. It then counts write strobes, which must stay unchanged. It also checks that the next address byte is acknowledged and that a following write lands.

// File: rtl/smbus_reg_target.sv
module smbus_reg_target #(
  parameter logic [3:0] ADDR_HI = 4'b0011,
  parameter logic [7:0] ID_IDX  = 8'h20,
  parameter logic [7:0] ID_HI   = 8'h60,
  parameter logic [7:0] ID_LO   = 8'h13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst_n,
  input  logic [2:0] addr_strap,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_idx,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IDX, S_WDAT, S_ACK, S_TX} st_t;

  st_t        st, nxt;
  logic [2:0] scl_p, sda_p, addr_lo;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic       ack_ph;

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start_c  = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_c   = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire [7:0] rx_byte = {sh[6:0], sda_p[1]};
  wire id_hit = (reg_idx[7:1] == ID_IDX[7:1]);
  wire [7:0] rd_val = id_hit ? (reg_idx[0] ? ID_LO : ID_HI) : reg_rdata;
  wire addr_ok = (rx_byte[7:1] == {ADDR_HI, addr_lo});

  always_ff @(posedge clk)
    if (!rst_n || !ext_rst_n) addr_lo <= addr_strap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      ack_ph <= 1'b0; sda_oe <= 1'b0; reg_idx <= '0; reg_wdata <= '0;
      reg_we <= 1'b0; reg_re <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; ack_ph <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_IDX, S_WDAT: if (scl_rise) begin
            sh  <= rx_byte;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              cnt <= '0; ack_ph <= 1'b0; st <= S_ACK;
              if (st == S_ADDR) begin
                if (!addr_ok) st <= S_IDLE;
                else if (rx_byte[0]) begin
                  nxt <= S_TX; tx <= rd_val; reg_re <= 1'b1;
                end else nxt <= S_IDX;
              end else if (st == S_IDX) begin
                reg_idx <= rx_byte; nxt <= S_WDAT;
              end else begin
                reg_wdata <= rx_byte; reg_we <= !id_hit; nxt <= S_IDLE;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            if (!ack_ph) begin
              ack_ph <= 1'b1; sda_oe <= 1'b1;
            end else begin
              ack_ph <= 1'b0; st <= nxt; cnt <= '0;
              if (nxt == S_TX) begin
                sda_oe <= ~tx[7]; tx <= {tx[6:0], 1'b0};
              end else sda_oe <= 1'b0;
            end
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= S_IDLE;
              end else begin
                sda_oe <= ~tx[7]; tx <= {tx[6:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module smbus_reg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_re
);
  assert_oe_rise_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  assert_re_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  assert_we_re_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe && !reg_we && !reg_re));
endmodule

bind smbus_reg_target smbus_reg_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_p[1]), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/tb_smbus_reg_target.sv
module tb_smbus_reg_target;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0, ext_rst_n = 1'b1;
  logic [2:0] addr_strap = 3'd5;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [7:0] reg_idx, reg_wdata, reg_rdata;
  logic [7:0] mem [0:255];
  wire sda_line = m_sda & ~sda_oe;
  int n_chk = 0, n_fail = 0, we_cnt = 0, re_cnt = 0;
  logic [7:0] last_idx, last_data;
  logic done = 1'b0;

  always #4 clk = ~clk;

  smbus_reg_target dut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .addr_strap(addr_strap),
    .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_idx];

  always @(posedge clk) begin
    if (reg_we) begin
      we_cnt <= we_cnt + 1; last_idx <= reg_idx; last_data <= reg_wdata;
      mem[reg_idx] <= reg_wdata;
    end
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = ~sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl = 1'b1; wq(); b[i] = sda_line; wq(); m_scl = 1'b0; wq();
    end
    wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] d,
                          output logic [2:0] acks);
    acks = 3'b000;
    i2c_start();
    send_byte({a, 1'b0}, acks[0]);
    if (acks[0]) begin
      send_byte(idx, acks[1]);
      send_byte(d, acks[2]);
    end
    i2c_stop();
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] idx, output logic [7:0] d,
                         output logic ok);
    logic a0, a1, a2;
    d = 8'h00;
    i2c_start();
    send_byte({a, 1'b0}, a0);
    send_byte(idx, a1);
    i2c_start();
    send_byte({a, 1'b1}, a2);
    if (a2) recv_byte(d);
    i2c_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 0);
    chk("R1 strobes in reset", {reg_we, reg_re}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 quiet after reset", {sda_oe, reg_we, reg_re}, 0);
  endtask

  task automatic t_write();
    logic [2:0] acks; int w0;
    w0 = we_cnt;
    do_write(7'h1D, 8'h03, 8'hA5, acks);
    chk("R2 address ack", acks[0], 1);
    chk("R4 all bytes acked", acks, 3'b111);
    chk("R4 one strobe", we_cnt - w0, 1);
    chk("R4 index", last_idx, 8'h03);
    chk("R4 data", last_data, 8'hA5);
    chk("R9 released after stop", sda_oe, 0);
  endtask

  task automatic t_read();
    logic [7:0] d; logic ok; int r0;
    r0 = re_cnt;
    do_read(7'h1D, 8'h03, d, ok);
    chk("R5 read acks", ok, 1);
    chk("R5 read data", d, 8'hA5);
    chk("R5 one read strobe", re_cnt - r0, 1);
    do_read(7'h1D, 8'h4C, d, ok);
    chk("R5 read data other idx", d, 8'h4C ^ 8'h5A);
    chk("R9 released after read", sda_oe, 0);
  endtask

  task automatic t_mismatch();
    logic [2:0] acks; int w0;
    w0 = we_cnt;
    do_write(7'h1C, 8'h05, 8'h11, acks);
    chk("R3 low bits mismatch nack", acks[0], 0);
    do_write(7'h5D, 8'h05, 8'h11, acks);
    chk("R3 upper bits mismatch nack", acks[0], 0);
    chk("R3 no strobe", we_cnt - w0, 0);
  endtask

  task automatic t_id();
    logic [7:0] d; logic ok; logic [2:0] acks; int w0;
    do_read(7'h1D, 8'h20, d, ok);
    chk("R6 id high", d, 8'h60);
    do_read(7'h1D, 8'h21, d, ok);
    chk("R6 id low", d, 8'h13);
    w0 = we_cnt;
    do_write(7'h1D, 8'h20, 8'h77, acks);
    chk("R6 id write acked", acks, 3'b111);
    chk("R6 id write dropped", we_cnt - w0, 0);
  endtask

  task automatic t_strap();
    logic [2:0] acks;
    addr_strap = 3'd2;
    wq(2);
    do_write(7'h1D, 8'h06, 8'h01, acks);
    chk("R7 old address kept", acks[0], 1);
    do_write(7'h1A, 8'h06, 8'h01, acks);
    chk("R7 new strap ignored", acks[0], 0);
    ext_rst_n = 1'b0; repeat (4) @(negedge clk); ext_rst_n = 1'b1; wq();
    do_write(7'h1A, 8'h06, 8'h02, acks);
    chk("R7 relatched address", acks[0], 1);
    do_write(7'h1D, 8'h06, 8'h02, acks);
    chk("R7 old address gone", acks[0], 0);
  endtask

  task automatic t_abort();
    logic a; logic [2:0] acks; int w0;
    w0 = we_cnt;
    i2c_start();
    send_byte({7'h1A, 1'b0}, a);
    send_byte(8'h09, a);
    send_bits(8'hF0, 4);
    i2c_start();
    send_byte({7'h1A, 1'b0}, a);
    chk("R8 address after restart acked", a, 1);
    i2c_stop();
    chk("R8 aborted byte no strobe", we_cnt - w0, 0);
    do_write(7'h1A, 8'h09, 8'h3C, acks);
    chk("R8 later write lands", {we_cnt - w0, last_data}, {32'd1, 8'h3C} >> 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    t_reset();
    wq(2);
    t_write();
    t_read();
    t_mismatch();
    t_id();
    t_strap();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule